// File: doc/BRIEF.md
# Single-Clock Show-Ahead Queue with Acknowledge Pop

This block is a first-in first-out word buffer that runs on one clock and holds up to `DEPTH` words. A producer offers a word by raising `valid_i` with the word on `data_i`. The queue accepts the word at a clock edge whenever `ready_o` is high, which means at least one slot is free.

On the consumer side the oldest stored word is already on `data_o` whenever `valid_o` is high. The consumer takes that word by raising `yumi_i` for one edge, and the next word (if any) appears after that edge. Driving `rst_n_i` low at a clock edge discards everything stored.

A push and a pop in the same cycle both take effect. The producer must not offer a word while the queue is full, and the consumer must not pop while it is empty. The block's behaviour in either case is left open.

Top module: `vy_queue`

## Requirements
- R1: A clock edge with `rst_n_i` low empties the queue: in the following cycle `valid_o` is 0 and `ready_o` is 1, and this holds until the next accepted push.
- R2: `ready_o` is 1 exactly when fewer than `DEPTH` words are stored, so it goes low in the cycle after the push that fills the last slot.
- R3: `valid_o` is 1 exactly when at least one word is stored, and while it is 1 `data_o` equals the oldest stored word.
- R4: A word on `data_i` with `valid_i` high at an edge where `ready_o` is 1 is stored. If the queue was empty, it is on `data_o` with `valid_o` high in the cycle after that edge.
- R5: `yumi_i` high at an edge while `valid_o` is 1 removes the word on `data_o`, and the next older word is on `data_o` in the cycle after that edge.
- R6: Words leave in the order they entered, including across wrap-around of the storage ring and over many fill-and-drain rounds.
- R7: A push and a pop at the same edge, with 1 to `DEPTH`-1 words stored, both take effect: the occupancy is unchanged and order is kept.
- R8: While `valid_o` is 1 and `yumi_i` is low, `valid_o` stays high and `data_o` does not change at the next edge, even if a push is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both sides |
| rst_n_i | input | 1 | Synchronous reset, active low; empties the queue |
| data_i | input | WIDTH | Word offered by the producer |
| valid_i | input | 1 | Producer offers `data_i` this cycle |
| ready_o | output | 1 | At least one free slot |
| valid_o | output | 1 | Queue not empty; `data_o` holds the oldest word |
| data_o | output | WIDTH | Oldest stored word |
| yumi_i | input | 1 | Consumer takes the word on `data_o` at this edge |

## Verification
The assertions assume that the producer never offers a word while `ready_o` is low, and that the consumer never raises `yumi_i` while `valid_o` is low. Under those assumptions the occupancy stays within zero to `DEPTH` and the head word can only change through a pop.

The stimulus respects both rules by construction. Every push and pop request is filtered against the bench's own occupancy count before it is driven, so the queue never sees an illegal request. The phases still reach both end points, and they exercise the simultaneous push-and-pop case at every legal occupancy.

// File: rtl/vy_queue_pkg.sv
package vy_queue_pkg;

  typedef enum logic [1:0] {
    OCC_HOLD = 2'b00,
    OCC_INC  = 2'b01,
    OCC_DEC  = 2'b10,
    OCC_SWAP = 2'b11
  } occ_op_e;

  function automatic occ_op_e occ_op(input logic push, input logic pop);
    return occ_op_e'({pop, push});
  endfunction

endpackage

// File: rtl/vy_queue_ptr.sv
module vy_queue_ptr #(
  parameter int DEPTH = 8,
  parameter int PW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i)   ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  // R6: the ring index never leaves the storage range
  a_r6_ptr_in_range: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ptr_q <= LAST);

  // R6: an advance moves by one slot or wraps to zero
  a_r6_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    adv_i |=> (ptr_q == $past(ptr_q) + 1'b1) || (ptr_q == '0));
endmodule

// File: rtl/vy_queue_store.sv
module vy_queue_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int PW    = 3
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/vy_queue_occ.sv
module vy_queue_occ
  import vy_queue_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic push_i,
  input  logic pop_i,
  output logic full_o,
  output logic empty_o
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [CW-1:0] count_q, count_d;
  logic          full_q, empty_q;

  always_comb begin
    unique case (occ_op(push_i, pop_i))
      OCC_INC: count_d = count_q + 1'b1;
      OCC_DEC: count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      count_q <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      count_q <= count_d;
      full_q  <= (count_d == CAP);
      empty_q <= (count_d == '0);
    end
  end

  assign full_o  = full_q;
  assign empty_o = empty_q;

  a_r1_reset_empties: assert property (@(posedge clk_i)
    !rst_n_i |=> empty_q && !full_q && count_q == '0);

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    count_q <= CAP);

  a_r2_full_flag: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    full_q == (count_q == CAP));

  a_r3_empty_flag: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    empty_q == (count_q == '0));

  a_r7_swap_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    push_i && pop_i |=> $stable(count_q));
endmodule

// File: rtl/vy_queue.sv
module vy_queue #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  input  logic             yumi_i
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          full_w, empty_w, push_w, pop_w;
  logic [PW-1:0] wptr_w, rptr_w;

  assign ready_o = !full_w;
  assign valid_o = !empty_w;
  assign push_w  = valid_i && !full_w;
  assign pop_w   = yumi_i && !empty_w;

  vy_queue_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .adv_i(push_w), .ptr_o(wptr_w));

  vy_queue_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .adv_i(pop_w), .ptr_o(rptr_w));

  vy_queue_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .push_i(push_w), .pop_i(pop_w),
    .full_o(full_w), .empty_o(empty_w));

  vy_queue_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk_i(clk_i), .we_i(push_w), .waddr_i(wptr_w), .wdata_i(data_i),
    .raddr_i(rptr_w), .rdata_o(data_o));

  initial begin
    if (DEPTH < 2) $error("vy_queue: DEPTH must be at least 2");
  end

  a_r8_head_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    valid_o && !yumi_i |=> valid_o && $stable(data_o));

  a_r4_push_shows: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !valid_o && valid_i |=> valid_o && data_o == $past(data_i));

  a_r5_pop_last_empties: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    valid_o && yumi_i && !valid_i && (rptr_w + 1'b1 == wptr_w) && ready_o |=> !valid_o);
endmodule

// File: tb/vy_queue_tb_top.sv
module vy_queue_tb_top;
  localparam int  WIDTH = 16;
  localparam int  DEPTH = 8;
  localparam time CLK_PERIOD = 10ns;

  logic             clk_i = 1'b0;
  logic             rst_n_i = 1'b0;
  logic [WIDTH-1:0] data_i = '0;
  logic             valid_i = 1'b0;
  logic             yumi_i = 1'b0;
  logic             ready_o, valid_o;
  logic [WIDTH-1:0] data_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [WIDTH-1:0] model_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vy_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .data_i(data_i), .valid_i(valid_i),
    .ready_o(ready_o), .valid_o(valid_o), .data_o(data_o), .yumi_i(yumi_i));

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // monitor: compare flags and head word with the scoreboard
  task automatic monitor(input string req);
    check({req, "/R2 ready"}, WIDTH'(ready_o), WIDTH'(model_q.size() < DEPTH));
    check({req, "/R3 valid"}, WIDTH'(valid_o), WIDTH'(model_q.size() > 0));
    if (model_q.size() > 0) check({req, "/R3 head"}, data_o, model_q[0]);
  endtask

  // driver: one cycle; requests filtered to stay legal
  task automatic cycle(input bit v, input logic [WIDTH-1:0] d, input bit y, input string req);
    bit vv, yy;
    vv = v && (model_q.size() < DEPTH);
    yy = y && (model_q.size() > 0);
    valid_i = vv;
    data_i  = d;
    yumi_i  = yy;
    #1;
    if (yy) check({req, "/R5 popped word"}, data_o, model_q[0]);
    @(posedge clk_i);
    if (yy) void'(model_q.pop_front());
    if (vv) model_q.push_back(d);
    #(CLK_PERIOD/4);
    valid_i = 1'b0;
    yumi_i  = 1'b0;
    monitor(req);
  endtask

  task automatic do_reset();
    rst_n_i = 1'b0;
    valid_i = 1'b0;
    yumi_i  = 1'b0;
    repeat (2) @(posedge clk_i);
    model_q.delete();
    #(CLK_PERIOD/4);
    rst_n_i = 1'b1;
    check("R1 valid after reset", WIDTH'(valid_o), '0);
    check("R1 ready after reset", WIDTH'(ready_o), WIDTH'(1));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] held;
    do_reset();
    cycle(0, '0, 0, "R1 idle");

    // R4: single push to empty, then pop; R5
    cycle(1, 16'hA5A5, 0, "R4 first push");
    cycle(0, '0, 1, "R5 pop to empty");

    // R2: fill to full, R6 drain in order
    for (int i = 0; i < DEPTH; i++) cycle(1, WIDTH'(16'h1000 + i), 0, "R2 fill");
    check("R2 ready low when full", WIDTH'(ready_o), '0);
    for (int i = 0; i < DEPTH; i++) cycle(0, '0, 1, "R6 drain");
    check("R3 valid low when drained", WIDTH'(valid_o), '0);

    // R7: simultaneous push and pop at each occupancy 1..DEPTH-1
    for (int occ = 1; occ < DEPTH; occ++) begin
      for (int i = 0; i < occ; i++) cycle(1, WIDTH'(16'h2000 + occ*16 + i), 0, "R7 setup");
      for (int k = 0; k < 3; k++) cycle(1, WIDTH'(16'h3000 + occ*16 + k), 1, "R7 swap");
      check("R7 occupancy kept", WIDTH'(valid_o), WIDTH'(1));
      while (model_q.size() > 0) cycle(0, '0, 1, "R7 drain");
    end

    // R8: head holds while not popped, even with pushes
    cycle(1, 16'hBEEF, 0, "R8 load");
    held = data_o;
    for (int i = 0; i < 3; i++) begin
      cycle(1, WIDTH'(16'h4000 + i), 0, "R8 hold");
      check("R8 head stable", data_o, held);
    end

    // R6: wrap-around with mixed traffic
    for (int i = 0; i < 300; i++)
      cycle((i % 3) != 2, WIDTH'(i * 37 + 5), (i % 5) < 2 || model_q.size() == DEPTH, "R6 mixed");
    while (model_q.size() > 0) cycle(0, '0, 1, "R6 final drain");

    // R1: reset while partly full
    for (int i = 0; i < 5; i++) cycle(1, WIDTH'(16'h5000 + i), 0, "R1 preload");
    do_reset();
    cycle(0, '0, 0, "R1 stays empty");
    cycle(1, 16'h6001, 0, "R4 push after reset");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule